// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block holds a set of alarm values for a calendar clock and compares them against the running time once per second. Six calendar fields can each be armed on their own: seconds, minutes, hours, day of month, month and a three-digit year. The time itself is kept elsewhere. It arrives on input ports in BCD and is already advanced when the one-second strobe `sec_tick` is high. A master arm bit gates the whole comparison.

The armed fields are OR-combined. A single armed field that equals the current value on a strobe cycle is enough to latch the alarm. The alarm stays latched on `alarm_irq` until software clears it with a write-one-to-clear write. Software programs the block through a simple write port: a 3-bit select picks the control word, one of the six alarm fields, or the clear action. Each stored alarm field keeps only the bits that its field width allows.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset `alarm_irq` is 0, the control word is 0 and every stored alarm field is 0. A zero seconds alarm therefore matches a current seconds value of 0x00 once it is armed.
- R2: When control bit 6 (master arm) is 0, no strobe sets the alarm, even if fields match.
- R3: Control bits 0 to 5 arm seconds, minutes, hours, day, month and year, in that order. A matching field whose arm bit is 0 does not set the alarm.
- R4: On a strobe cycle with the master arm set, the alarm is set if any one armed field equals its current value, even when the other armed fields differ.
- R5: Writes keep only the low bits of a field: 7 bits for seconds and minutes, 6 for hours and day, 5 for month and 12 for year. The write selects are 1 sec, 2 min, 3 hour, 4 day, 5 month and 6 year, with the data on `wr_data`.
- R6: The year compare covers 12 bits. Bits 7:0 hold the two low BCD digits and bits 11:8 hold the hundreds digit, so a difference in any one digit is a mismatch.
- R7: The compare only takes effect in a cycle with `sec_tick` high. `alarm_irq` rises on the clock edge that ends that cycle.
- R8: `alarm_irq` stays high until a write with select 7 and `wr_data` bit 1 set. A select-7 write with bit 1 clear leaves it high.
- R9: If a strobe match and a clear write fall in the same cycle, the alarm stays set.
- R10: The month compare uses the `cur_mon` input exactly as given. This input is the zero-based month in BCD, and no offset is applied.
- R11: A select-0 write stores `wr_data[6:0]` as the control word, and the upper data bits are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target: 0 control, 1 to 6 alarm fields, 7 clear |
| wr_data | input | 16 | Write data |
| sec_tick | input | 1 | One-second strobe; current time inputs are already updated |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_mday | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, zero-based, BCD |
| cur_year | input | 12 | Current year, three BCD digits |
| alarm_irq | output | 1 | Latched alarm interrupt |

## Verification
The hardest situation to reach is a strobe match that lands in the same cycle as a clear write. The stimulus drives select 7 and `sec_tick` together while an armed field matches, and then checks that the alarm survives. A further difficulty is that the masked upper bits of a stored field cannot be read back. The bench therefore writes all-ones values and shows the mask through the compare instead: it offers current values equal to the masked pattern, which must fire, and values that carry the dropped bits, which must not.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int FIELD_W    = 12;
  localparam int DATA_W     = 16;
  localparam int CTRL_W     = 7;
  localparam int ARM_BIT    = 6;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_SEC   = 3'd1,
    SEL_MIN   = 3'd2,
    SEL_HOUR  = 3'd3,
    SEL_DAY   = 3'd4,
    SEL_MON   = 3'd5,
    SEL_YEAR  = 3'd6,
    SEL_CLEAR = 3'd7
  } wr_sel_t;

  // Keep-mask for a stored alarm field, by field index (0 = seconds).
  function automatic logic [FIELD_W-1:0] field_mask(input int idx);
    case (idx)
      0, 1:    field_mask = 12'h07F;
      2, 3:    field_mask = 12'h03F;
      4:       field_mask = 12'h01F;
      default: field_mask = 12'hFFF;
    endcase
  endfunction

  // Write select that addresses field index idx.
  function automatic logic [2:0] field_sel(input int idx);
    field_sel = 3'(idx + 1);
  endfunction

  // Equality of a stored alarm field and the current time field.
  function automatic logic field_equal(input logic [FIELD_W-1:0] alm,
                                       input logic [FIELD_W-1:0] cur);
    field_equal = (alm == cur);
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int FW = FIELD_W,
  parameter int DW = DATA_W,
  parameter int CW = CTRL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [2:0]             wr_sel,
  input  logic [DW-1:0]          wr_data,
  output logic [CW-1:0]          ctrl,
  output logic [NF-1:0][FW-1:0]  alm,
  output logic                   clear_req
);
  logic unused_hi;
  assign unused_hi = ^wr_data[DW-1:FW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl <= '0;
    else if (wr_en && wr_sel == SEL_CTRL)
      ctrl <= wr_data[CW-1:0];
  end

  for (genvar f = 0; f < NF; f++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        alm[f] <= '0;
      else if (wr_en && wr_sel == field_sel(f))
        alm[f] <= wr_data[FW-1:0] & field_mask(f);
    end

    // R5: stored value never carries bits outside the field width
    a_r5_field_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == field_sel(f)) |=> ((alm[f] & ~field_mask(f)) == '0));
  end

  assign clear_req = wr_en && (wr_sel == SEL_CLEAR) && wr_data[1];

  // R11: control write takes the low data bits
  a_r11_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTRL) |=> (ctrl == $past(wr_data[CW-1:0])));
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int FW = FIELD_W,
  parameter int CW = CTRL_W,
  parameter int AB = ARM_BIT
) (
  input  logic [CW-1:0]         ctrl,
  input  logic [NF-1:0][FW-1:0] alm,
  input  logic [NF-1:0][FW-1:0] cur,
  output logic [NF-1:0]         field_hit,
  output logic                  any_hit
);
  for (genvar f = 0; f < NF; f++) begin : g_cmp
    assign field_hit[f] = ctrl[f] && field_equal(alm[f], cur[f]);
  end

  assign any_hit = ctrl[AB] && (|field_hit);

  always_comb begin
    // R3: a field reports a hit only while armed
    a_r3_armed_only: assert (((field_hit & ~ctrl[NF-1:0]) == '0));
  end
endmodule

// File: rtl/alarm_pending.sv
module alarm_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic clear_req,
  output logic pend
);
  logic set_evt;
  assign set_evt = tick && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend <= 1'b0;
    else if (set_evt)
      pend <= 1'b1;
    else if (clear_req)
      pend <= 1'b0;
  end

  // R7: a qualified match latches the alarm
  a_r7_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit) |=> pend);
  // R7: without a strobe the alarm cannot rise
  a_r7_no_tick_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !tick) |=> !pend);
  // R8: held until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clear_req) |=> pend);
  // R8: clear drops it when no match competes
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_req && !(tick && hit)) |=> !pend);
  // R9: match wins over a simultaneous clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_req && tick && hit) |=> pend);
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int FW = FIELD_W,
  parameter int DW = DATA_W,
  parameter int CW = CTRL_W,
  parameter int AB = ARM_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          sec_tick,
  input  logic [7:0]    cur_sec,
  input  logic [7:0]    cur_min,
  input  logic [7:0]    cur_hour,
  input  logic [7:0]    cur_mday,
  input  logic [7:0]    cur_mon,
  input  logic [11:0]   cur_year,
  output logic          alarm_irq
);
  logic [CW-1:0]         ctrl;
  logic [NF-1:0][FW-1:0] alm;
  logic [NF-1:0][FW-1:0] cur;
  logic [NF-1:0]         field_hit;
  logic                  any_hit;
  logic                  clear_req;
  logic                  pend;

  assign cur[0] = FW'(cur_sec);
  assign cur[1] = FW'(cur_min);
  assign cur[2] = FW'(cur_hour);
  assign cur[3] = FW'(cur_mday);
  assign cur[4] = FW'(cur_mon);
  assign cur[5] = FW'(cur_year);

  alarm_regs #(.NF(NF), .FW(FW), .DW(DW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .ctrl      (ctrl),
    .alm       (alm),
    .clear_req (clear_req)
  );

  alarm_match #(.NF(NF), .FW(FW), .CW(CW), .AB(AB)) u_match (
    .ctrl      (ctrl),
    .alm       (alm),
    .cur       (cur),
    .field_hit (field_hit),
    .any_hit   (any_hit)
  );

  alarm_pending u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sec_tick),
    .hit       (any_hit),
    .clear_req (clear_req),
    .pend      (pend)
  );

  assign alarm_irq = pend;

  // R2: with the master arm off, an idle alarm stays idle
  a_r2_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[AB] && !pend) |=> !pend);
  // R4: any single armed hit on a strobe latches the alarm
  a_r4_any_field: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && ctrl[AB] && (field_hit != '0)) |=> alarm_irq);
endmodule

// File: tb/cal_alarm_cmp_tb.sv
module cal_alarm_cmp_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [15:0] wr_data = 16'h0;
  logic        sec_tick = 1'b0;
  logic [7:0]  cur_sec = 8'h0, cur_min = 8'h0, cur_hour = 8'h0;
  logic [7:0]  cur_mday = 8'h0, cur_mon = 8'h0;
  logic [11:0] cur_year = 12'h0;
  logic        alarm_irq;

  logic [7:0]  t_sec = 8'h0, t_min = 8'h0, t_hour = 8'h0, t_day = 8'h0, t_mon = 8'h0;
  logic [11:0] t_year = 12'h0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_alarm_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_tick(sec_tick), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_mday(cur_mday), .cur_mon(cur_mon), .cur_year(cur_year), .alarm_irq(alarm_irq)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s alarm_irq actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected alarm_irq after its edge queued.
  task automatic drive(input bit en, input logic [2:0] sel, input logic [15:0] d,
                       input bit tk, input bit exp, input string tag);
    @(negedge clk);
    wr_en = en; wr_sel = sel; wr_data = d; sec_tick = tk;
    cur_sec = t_sec; cur_min = t_min; cur_hour = t_hour;
    cur_mday = t_day; cur_mon = t_mon; cur_year = t_year;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d, input bit exp, input string tag);
    drive(1'b1, sel, d, 1'b0, exp, tag);
  endtask
  task automatic tick(input bit exp, input string tag);
    drive(1'b0, 3'd0, 16'h0, 1'b1, exp, tag);
  endtask
  task automatic idle(input bit exp, input string tag);
    drive(1'b0, 3'd0, 16'h0, 1'b0, exp, tag);
  endtask
  task automatic clr(input string tag);
    drive(1'b1, 3'd7, 16'h0002, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares each queued expectation just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(alarm_irq, e, t);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check(alarm_irq, 1'b0, "R1 reset value");

    // R1: reset fields are zero, so armed seconds match 0x00
    wr(3'd0, 16'h0041, 1'b0, "R1 arm");
    tick(1'b1, "R1 zero alarm matches");
    idle(1'b1, "R8 held");
    clr("R8 cleared");

    t_sec = 8'h30; t_min = 8'h12; t_hour = 8'h05; t_day = 8'h15; t_mon = 8'h03; t_year = 12'h024;
    wr(3'd1, 16'h0030, 1'b0, "R5 sec write");
    wr(3'd0, 16'h0001, 1'b0, "R2 no master");
    tick(1'b0, "R2 master arm off");
    wr(3'd0, 16'h007E, 1'b0, "R3 ctrl");
    tick(1'b0, "R3 seconds unarmed");
    wr(3'd0, 16'h0041, 1'b0, "R7 ctrl");
    idle(1'b0, "R7 no strobe");
    tick(1'b1, "R4 single field");
    tick(1'b1, "R8 sticky on repeat");
    wr(3'd7, 16'h0001, 1'b1, "R8 bit1 clear no effect");
    clr("R8 cleared");
    wr(3'd0, 16'h007F, 1'b0, "R4 ctrl all");
    tick(1'b1, "R4 OR of fields");
    drive(1'b1, 3'd7, 16'h0002, 1'b1, 1'b1, "R9 set beats clear");
    clr("R9 cleared");
    t_sec = 8'h31;
    tick(1'b0, "R4 no field equal");

    // R5 masks
    wr(3'd1, 16'hFFFF, 1'b0, "R5 sec");
    wr(3'd0, 16'h0041, 1'b0, "R5 ctrl");
    t_sec = 8'h7F; tick(1'b1, "R5 sec 7 bits");
    clr("R5 clr");
    t_sec = 8'hFF; tick(1'b0, "R5 sec bit7 dropped");
    wr(3'd2, 16'h00FF, 1'b0, "R5 min");
    wr(3'd0, 16'h0042, 1'b0, "R5 ctrl");
    t_min = 8'h7F; tick(1'b1, "R5 min 7 bits");
    clr("R5 clr");
    wr(3'd3, 16'h00FF, 1'b0, "R5 hour");
    wr(3'd0, 16'h0044, 1'b0, "R5 ctrl");
    t_hour = 8'h3F; tick(1'b1, "R5 hour 6 bits");
    clr("R5 clr");
    t_hour = 8'h7F; tick(1'b0, "R5 hour bit6 dropped");
    wr(3'd4, 16'h00FF, 1'b0, "R5 day");
    wr(3'd0, 16'h0048, 1'b0, "R5 ctrl");
    t_day = 8'h3F; tick(1'b1, "R5 day 6 bits");
    clr("R5 clr");
    wr(3'd5, 16'h00FF, 1'b0, "R5 mon");
    wr(3'd0, 16'h0050, 1'b0, "R5 ctrl");
    t_mon = 8'h1F; tick(1'b1, "R5 month 5 bits");
    clr("R5 clr");
    wr(3'd6, 16'hF123, 1'b0, "R5 year");
    wr(3'd0, 16'h0060, 1'b0, "R5 ctrl");
    t_year = 12'h123; tick(1'b1, "R6 year three digits");
    clr("R6 clr");
    t_year = 12'h023; tick(1'b0, "R6 hundreds differ");
    t_year = 12'h124; tick(1'b0, "R6 units differ");

    // R10 month as given
    wr(3'd5, 16'h0005, 1'b0, "R10 mon");
    wr(3'd0, 16'h0050, 1'b0, "R10 ctrl");
    t_mon = 8'h05; tick(1'b1, "R10 zero-based month equal");
    clr("R10 clr");
    t_mon = 8'h06; tick(1'b0, "R10 no offset");

    // R11 control takes low 7 bits only
    t_mon = 8'h05;
    wr(3'd0, 16'hFF90, 1'b0, "R11 ctrl upper dropped");
    tick(1'b0, "R11 master bit not set");
    wr(3'd0, 16'h0050, 1'b0, "R11 ctrl");
    tick(1'b1, "R11 armed again");
    idle(1'b1, "R8 final hold");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule